// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one burst request into a stream of column addresses, one per clock, for a synchronous DRAM burst. A request carries a starting column, a three-bit length code and an order select (sequential or interleaved). A single-cycle start pulse launches the burst. On each following cycle the block presents one column address with a valid flag, and it raises a last flag on the final beat. The block fits a memory controller that needs to know which column each data beat belongs to. It fits equally well inside a behavioural memory model that must fetch words in the order the device would.

Fixed-length bursts never leave the aligned block of BL columns that contains the start column. Only the low log2(BL) bits move: sequential order adds the beat count and drops the carry, and interleaved order XORs the beat count into the start column. A full-row length makes the whole column field count upward and wrap at the row end, and it runs until a stop request ends it. The control is a two-state machine. `ST_IDLE` moves to `ST_BEAT` on LAUNCH, which is an accepted start. `ST_BEAT` moves to itself on STEP, which is an ordinary beat, and on CHAIN, which is a start accepted on the final beat or together with a stop. It returns to `ST_IDLE` on FINISH, the final beat with no start, and on ABORT, a stop with no start.

Top module: `burst_col_gen`

## Requirements
- R1: Length code 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4 and 3'b011 gives 8. The reserved codes 3'b100, 3'b101 and 3'b110 give 1 beat. `last_o` is high exactly on the final beat of a fixed-length burst.
- R2: A start pulse sampled at a clock edge while idle makes `valid_o` high from that edge, with `col_o` equal to the requested column. A start pulse during a beat that is neither final nor stopped is ignored.
- R3: In a fixed-length burst of BL beats, every column bit above the low log2(BL) bits equals the corresponding bit of the start column.
- R4: In sequential order (`ilv_i`=0), the low bits of beat k are (start low bits + k) mod BL. For example, BL=4 from column 5 gives 5,6,7,4.
- R5: In interleaved order (`ilv_i`=1), the low bits of beat k are (start low bits) XOR k.
- R6: BL=1 gives only the requested column. BL=2 gives the requested column and then its partner. Both hold in either order.
- R7: Length code 3'b111 is a full-row burst. The column is (start + k) mod 2^COL_W whatever `ilv_i` is, `last_o` never rises, and beats continue until a stop.
- R8: `stop_i` high during a beat ends the burst, and `valid_o` is low on the next cycle unless a start is sampled on the same edge. `stop_i` while idle has no effect.
- R9: A start sampled on the final beat (or together with a stop) begins the new burst on the next cycle with no idle cycle between.
- R10: After reset and whenever idle, `valid_o` and `last_o` are low and `col_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst request pulse |
| start_col_i | input | COL_W | Requested starting column |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | Order select: 0 sequential, 1 interleaved |
| stop_i | input | 1 | Ends the current burst |
| valid_o | output | 1 | A column beat is presented |
| last_o | output | 1 | Final beat of a fixed-length burst |
| col_o | output | COL_W | Column address of the current beat |

## Verification
The bench builds the block with COL_W=6, so a row has 64 columns. With this width a full-row burst can be followed past the row end and back to column 0 in well under a hundred cycles, which exercises the R7 wraparound at the top of the column field. Six bits also leave three bits above the largest aligned block of eight. Start columns such as 45 and 63 therefore show that the upper bits stay fixed while the low bits wrap or interleave.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    localparam logic [2:0] LEN_CODE_1   = 3'b000;
    localparam logic [2:0] LEN_CODE_2   = 3'b001;
    localparam logic [2:0] LEN_CODE_4   = 3'b010;
    localparam logic [2:0] LEN_CODE_8   = 3'b011;
    localparam logic [2:0] LEN_CODE_ROW = 3'b111;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BEAT = 1'b1
    } beat_state_e;

endpackage

// File: rtl/burst_len_dec.sv
module burst_len_dec
    import burst_col_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [2:0]       code_i,
    output logic [COL_W-1:0] mask_o,
    output logic             full_o
);

    // mask_o holds BL-1: the set of column bits the burst may move
    always_comb begin
        mask_o = '0;
        full_o = 1'b0;
        case (code_i)
            LEN_CODE_2:   mask_o = COL_W'(1);
            LEN_CODE_4:   mask_o = COL_W'(3);
            LEN_CODE_8:   mask_o = COL_W'(7);
            LEN_CODE_ROW: begin
                mask_o = '1;
                full_o = 1'b1;
            end
            default:      mask_o = '0; // one beat, including reserved codes
        endcase
    end

endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] cnt_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    input  logic             full_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] seq_low;
    logic [COL_W-1:0] ilv_low;
    logic [COL_W-1:0] pick_low;

    assign seq_low  = base_i + cnt_i;   // carry past the mask is dropped below
    assign ilv_low  = base_i ^ cnt_i;
    assign pick_low = (ilv_i && !full_i) ? ilv_low : seq_low;

    // each column bit: moving bit from the chosen order, or fixed start bit
    for (genvar gi = 0; gi < COL_W; gi++) begin : g_bit
        assign col_o[gi] = mask_i[gi] ? pick_low[gi] : base_i[gi];
    end

endmodule

// File: rtl/burst_beat_fsm.sv
module burst_beat_fsm
    import burst_col_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             full_i,
    input  logic             ilv_i,
    output logic             busy_o,
    output logic             last_o,
    output logic [COL_W-1:0] cnt_o,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] mask_o,
    output logic             full_o,
    output logic             ilv_o
);

    beat_state_e      state_q, state_d;
    logic [COL_W-1:0] cnt_q, base_q, mask_q;
    logic             full_q, ilv_q;
    logic             accept;
    logic             at_end;

    assign at_end = (state_q == ST_BEAT) && !full_q && (cnt_q == mask_q);
    assign accept = start_i && ((state_q == ST_IDLE) || at_end || stop_i);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_BEAT;           // LAUNCH
            end
            ST_BEAT: begin
                if (accept)                state_d = ST_BEAT; // CHAIN
                else if (stop_i || at_end) state_d = ST_IDLE; // ABORT / FINISH
                else                       state_d = ST_BEAT; // STEP
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // burst context and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            base_q <= '0;
            mask_q <= '0;
            full_q <= 1'b0;
            ilv_q  <= 1'b0;
        end else if (accept) begin
            cnt_q  <= '0;
            base_q <= col_i;
            mask_q <= mask_i;
            full_q <= full_i;
            ilv_q  <= ilv_i;
        end else if (state_q == ST_BEAT) begin
            cnt_q  <= cnt_q + COL_W'(1);
        end
    end

    // outputs
    always_comb begin
        busy_o = (state_q == ST_BEAT);
        last_o = at_end;
        cnt_o  = cnt_q;
        base_o = base_q;
        mask_o = mask_q;
        full_o = full_q;
        ilv_o  = ilv_q;
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             ilv_i,
    input  logic             stop_i,
    output logic             valid_o,
    output logic             last_o,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             busy;
    logic             beat_last;
    logic [COL_W-1:0] cnt, base, mask;
    logic             full, ilv;
    logic [COL_W-1:0] beat_col;

    burst_len_dec #(.COL_W(COL_W)) u_dec (
        .code_i (len_code_i),
        .mask_o (dec_mask),
        .full_o (dec_full)
    );

    burst_beat_fsm #(.COL_W(COL_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .stop_i  (stop_i),
        .col_i   (start_col_i),
        .mask_i  (dec_mask),
        .full_i  (dec_full),
        .ilv_i   (ilv_i),
        .busy_o  (busy),
        .last_o  (beat_last),
        .cnt_o   (cnt),
        .base_o  (base),
        .mask_o  (mask),
        .full_o  (full),
        .ilv_o   (ilv)
    );

    burst_addr_calc #(.COL_W(COL_W)) u_calc (
        .base_i (base),
        .cnt_i  (cnt),
        .mask_i (mask),
        .ilv_i  (ilv),
        .full_i (full),
        .col_o  (beat_col)
    );

    assign valid_o = busy;
    assign last_o  = beat_last;
    assign col_o   = busy ? beat_col : '0;

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [2:0]       len_code_i,
    input logic             stop_i,
    input logic             valid_o,
    input logic             last_o,
    input logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] mask_c, beat_c;
    logic             full_c;
    logic             acc_c;

    assign acc_c = start_i && (!valid_o || last_o || stop_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_c <= '0;
            full_c <= 1'b0;
            beat_c <= '0;
        end else if (acc_c) begin
            beat_c <= '0;
            full_c <= (len_code_i == 3'b111);
            case (len_code_i)
                3'b001:  mask_c <= COL_W'(1);
                3'b010:  mask_c <= COL_W'(3);
                3'b011:  mask_c <= COL_W'(7);
                3'b111:  mask_c <= '1;
                default: mask_c <= '0;
            endcase
        end else if (valid_o) begin
            beat_c <= beat_c + COL_W'(1);
        end
    end

    a_r1_last_beat: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (last_o == (!full_c && (beat_c == mask_c))));

    a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !valid_o) |=> (valid_o && (col_o == $past(start_col_i))));

    a_r3_block_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && !$past(last_o) && !$past(stop_i))
        |-> ((col_o & ~mask_c) == ($past(col_o) & ~mask_c)));

    a_r7_row_no_last: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && full_c) |-> !last_o);

    a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && stop_i && !start_i) |=> !valid_o);

    a_r9_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && last_o) |=> (valid_o && (col_o == $past(start_col_i))));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ((col_o == '0) && !last_o));

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .len_code_i  (len_code_i),
    .stop_i      (stop_i),
    .valid_o     (valid_o),
    .last_o      (last_o),
    .col_o       (col_o)
);

// File: tb/burst_col_gen_tb.sv
`timescale 1ns/1ps
module burst_col_gen_tb;

    localparam int CW = 6;
    localparam int NV = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [CW-1:0] start_col_i = '0;
    logic [2:0]    len_code_i = '0;
    logic          ilv_i = 1'b0;
    logic          stop_i = 1'b0;
    logic          valid_o, last_o;
    logic [CW-1:0] col_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    burst_col_gen #(.COL_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .ilv_i(ilv_i), .stop_i(stop_i),
        .valid_o(valid_o), .last_o(last_o), .col_o(col_o)
    );

    // {start col, code, ilv, beats, expected beats 0..7}
    localparam logic [61:0] VEC [NV] = '{
        {6'd5,  3'd2, 1'b0, 4'd4, 6'd5, 6'd6, 6'd7, 6'd4, 6'd0, 6'd0, 6'd0, 6'd0},
        {6'd5,  3'd3, 1'b0, 4'd8, 6'd5, 6'd6, 6'd7, 6'd0, 6'd1, 6'd2, 6'd3, 6'd4},
        {6'd45, 3'd3, 1'b1, 4'd8, 6'd45,6'd44,6'd47,6'd46,6'd41,6'd40,6'd43,6'd42},
        {6'd21, 3'd2, 1'b1, 4'd4, 6'd21,6'd20,6'd23,6'd22,6'd0, 6'd0, 6'd0, 6'd0},
        {6'd21, 3'd2, 1'b0, 4'd4, 6'd21,6'd22,6'd23,6'd20,6'd0, 6'd0, 6'd0, 6'd0},
        {6'd9,  3'd1, 1'b1, 4'd2, 6'd9, 6'd8, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0},
        {6'd9,  3'd1, 1'b0, 4'd2, 6'd9, 6'd8, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0},
        {6'd33, 3'd0, 1'b1, 4'd1, 6'd33,6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0},
        {6'd24, 3'd3, 1'b1, 4'd8, 6'd24,6'd25,6'd26,6'd27,6'd28,6'd29,6'd30,6'd31},
        {6'd63, 3'd5, 1'b0, 4'd1, 6'd63,6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0},
        {6'd63, 3'd3, 1'b0, 4'd8, 6'd63,6'd56,6'd57,6'd58,6'd59,6'd60,6'd61,6'd62}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] code, input logic ilv);
        if (code == 3'd0 || code == 3'd1) return "R6 order";
        if (code[2])                      return "R1 reserved length";
        if (ilv)                          return "R5 interleaved (R3 block)";
        return "R4 sequential (R3 block)";
    endfunction

    task automatic launch(input int col, input logic [2:0] code, input logic ilv);
        @(negedge clk);
        start_i = 1'b1; start_col_i = CW'(col); len_code_i = code; ilv_i = ilv;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 valid at reset", int'(valid_o), 0);
        chk("R10 last at reset", int'(last_o), 0);
        chk("R10 col at reset", int'(col_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector walk: R1 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            logic [61:0] e;
            int n;
            e = VEC[v];
            n = int'(e[51:48]);
            launch(int'(e[61:56]), e[55:53], e[52]);
            for (int k = 0; k < n; k++) begin
                chk(tag_of(e[55:53], e[52]), int'(col_o), int'(e[47-6*k -: 6]));
                chk("R1 valid in burst", int'(valid_o), 1);
                chk("R1 last flag", int'(last_o), (k == n-1) ? 1 : 0);
                @(negedge clk);
            end
            chk("R1 burst length end", int'(valid_o), 0);
        end

        // R8 stop while idle has no effect
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R8 idle stop", int'(valid_o), 0);

        // R2 start ignored mid-burst
        launch(0, 3'd2, 1'b0);
        chk("R2 first beat", int'(col_o), 0);
        @(negedge clk);
        start_i = 1'b1; start_col_i = 6'd50;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 ignored start", int'(col_o), 2);
        @(negedge clk);
        chk("R2 ignored start last", int'(last_o), 1);
        @(negedge clk);
        chk("R2 burst ended", int'(valid_o), 0);

        // R8 stop mid-burst
        launch(16, 3'd3, 1'b0);
        @(negedge clk);
        @(negedge clk);
        chk("R8 beat before stop", int'(col_o), 18);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R8 stop ends burst", int'(valid_o), 0);

        // R9 back-to-back
        launch(4, 3'd1, 1'b0);
        @(negedge clk);
        chk("R9 last of first", int'(last_o), 1);
        start_i = 1'b1; start_col_i = 6'd12; len_code_i = 3'd0;
        @(negedge clk);
        start_i = 1'b0;
        chk("R9 no gap valid", int'(valid_o), 1);
        chk("R9 no gap col", int'(col_o), 12);
        chk("R9 no gap last", int'(last_o), 1);
        @(negedge clk);
        chk("R9 end", int'(valid_o), 0);

        // R7 full row, interleave ignored, wraps at 64
        launch(62, 3'd7, 1'b1);
        for (int k = 0; k < 70; k++) begin
            chk("R7 row column", int'(col_o), (62 + k) % 64);
            chk("R7 no last", int'(last_o), 0);
            if (k == 69) stop_i = 1'b1;
            @(negedge clk);
        end
        stop_i = 1'b0;
        chk("R7 stop ends row", int'(valid_o), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule